// File: doc/BRIEF.md
# Cartridge Bank-Switching Address Mapper

This block sits between a 16-bit host bus with a 24-bit byte address space (presented here as a 23-bit word address) and the storage on a game cartridge. Each word access is decoded and steered to external ROM, a small battery-backed SRAM, or open bus. A one-bit view register is loaded by any write into a small control window in low memory. When that bit is set, the lowest 256KB of the address space shows a fixed later 256KB chunk of ROM (byte offset 0x380000) instead of the start of ROM. All other ROM space is always mapped straight through.

The SRAM holds 16K words and appears above the ROM at byte 0x400000, mirrored twice across a 64KB window. SRAM decode takes priority over every ROM decode. Two static configuration inputs enable the SRAM and make it read-only. Read data comes from a register with one cycle of latency, whatever the target. ROM and SRAM arrays are outside the block and return data combinationally from the addresses it drives.

Top module: `cart_bank_mapper`

## Requirements
- R1: After reset the view bit is 0 and `bus_rdata` is 0xFFFF.
- R2: A write whose byte address lies in 0x000E00..0x000EFF (word 0x000700..0x00077F) loads the view bit from data bit 7. The new view applies from the next access.
- R3: With the view bit at 0, a read at byte address A in 0x000000..0x03FFFF returns the ROM word at byte A (ROM word address A>>1).
- R4: With the view bit at 1, a read at byte address A in 0x000000..0x03FFFF returns the ROM word at byte A+0x380000.
- R5: A read at byte address A in 0x040000..0x3FFFFF returns the ROM word at byte A, whatever the view bit.
- R6: With SRAM enabled, accesses to bytes 0x400000..0x40FFFF reach SRAM at word address equal to the low 14 bits of the bus word address, so the 32KB array repeats twice in the window. This decode is checked before any ROM decode.
- R7: With SRAM enabled and not read-only, a write in the SRAM window asserts `sram_we` with the bus data in that cycle, whatever the view bit.
- R8: With SRAM read-only, writes to the SRAM window leave its contents unchanged. With SRAM disabled, the window reads 0xFFFF and is never written.
- R9: A read at any address not decoded to ROM or SRAM returns 0xFFFF.
- R10: ROM is never written. Writes outside the control and SRAM windows change no state. A write to the control window does not write SRAM.
- R11: `bus_rdata` updates one clock after a read request and holds its value across idle and write cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_sram_en | input | 1 | Static: SRAM window decoded when 1 |
| cfg_sram_ro | input | 1 | Static: SRAM writes blocked when 1 |
| bus_req | input | 1 | Access request, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_waddr | input | 23 | Bus word address (byte address >> 1) |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |
| rom_addr | output | 21 | ROM word address |
| rom_rdata | input | 16 | ROM word at `rom_addr` |
| sram_addr | output | 14 | SRAM word address |
| sram_we | output | 1 | SRAM write strobe |
| sram_wdata | output | 16 | SRAM write data |
| sram_rdata | input | 16 | SRAM word at `sram_addr` |

## Verification
The assertions assume the two configuration inputs are stable while accesses are in flight. They also assume that `bus_req` is a single-cycle strobe per access and that ROM and SRAM return data in the same cycle as the address. The stimulus changes the configuration only between accesses, during idle cycles. It drives each request for one clock and models both arrays as combinational reads, so every check of read data falls in the cycle right after the request.

// File: rtl/cart_mapper_pkg.sv
// Shared types for the cartridge mapper.
// Assumes: a read resolves to exactly one target.
package cart_mapper_pkg;
    typedef enum logic [1:0] {
        TGT_OPEN = 2'd0,
        TGT_ROM  = 2'd1,
        TGT_SRAM = 2'd2
    } tgt_e;
endpackage

// File: rtl/cart_decode.sv
// Address decoder: picks the target of a word access and forms the ROM and
// SRAM word addresses. SRAM window is checked first, then ROM space.
// Assumes: BUS_AW > ROM_AW > LOW_WIN_AW, SRAM_WIN_AW >= SRAM_AW.
module cart_decode
    import cart_mapper_pkg::*;
#(
    parameter int BUS_AW      = 23,
    parameter int ROM_AW      = 21,
    parameter int SRAM_AW     = 14,
    parameter int SRAM_WIN_AW = 15,
    parameter int LOW_WIN_AW  = 17,
    parameter int CTL_AW      = 7,
    parameter logic [BUS_AW-1:0] SRAM_BASE_W = 23'h200000,
    parameter logic [BUS_AW-1:0] CTL_BASE_W  = 23'h000700,
    parameter logic [ROM_AW-1:0] SWAP_BASE_W = 21'h1C0000
) (
    input  logic [BUS_AW-1:0]  waddr,
    input  logic               view_hi,
    input  logic               sram_en,
    output tgt_e               tgt,
    output logic [ROM_AW-1:0]  rom_addr,
    output logic [SRAM_AW-1:0] sram_addr,
    output logic               ctl_hit
);
    localparam int ROM_TAG_W  = BUS_AW - ROM_AW;
    localparam int LOW_TAG_W  = ROM_AW - LOW_WIN_AW;

    logic sram_hit;
    logic rom_hit;
    logic low_hit;

    // Window hits for SRAM, ROM space, the swappable low window and control.
    always_comb begin
        sram_hit = sram_en &&
                   (waddr[BUS_AW-1:SRAM_WIN_AW] == SRAM_BASE_W[BUS_AW-1:SRAM_WIN_AW]);
        rom_hit  = (waddr[BUS_AW-1:ROM_AW] == ROM_TAG_W'(0));
        low_hit  = rom_hit && (waddr[ROM_AW-1:LOW_WIN_AW] == LOW_TAG_W'(0));
        ctl_hit  = (waddr[BUS_AW-1:CTL_AW] == CTL_BASE_W[BUS_AW-1:CTL_AW]);
    end

    // Target priority: SRAM before ROM, open bus otherwise.
    always_comb begin
        if (sram_hit)     tgt = TGT_SRAM;
        else if (rom_hit) tgt = TGT_ROM;
        else              tgt = TGT_OPEN;
    end

    // ROM address: low window relocated when the view bit is set.
    always_comb begin
        if (low_hit && view_hi)
            rom_addr = SWAP_BASE_W + ROM_AW'(waddr[LOW_WIN_AW-1:0]);
        else
            rom_addr = waddr[ROM_AW-1:0];
    end

    // SRAM address: low bits only, mirroring the array across its window.
    assign sram_addr = waddr[SRAM_AW-1:0];
endmodule

// File: rtl/cart_mode_reg.sv
// View register: one bit loaded from a data bit on writes to the control
// window, cleared by reset.
// Assumes: wr_en is a single-cycle write strobe from the bus.
module cart_mode_reg (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_en,
    input  logic ctl_hit,
    input  logic wbit,
    output logic view_hi
);
    // Load the view bit on a control write, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)                view_hi <= 1'b0;
        else if (wr_en && ctl_hit) view_hi <= wbit;
    end

    // R2
    view_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && ctl_hit) |=> (view_hi == $past(wbit)));

    // R10
    view_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && ctl_hit) |=> $stable(view_hi));
endmodule

// File: rtl/cart_rdata_reg.sv
// Read data register: captures the selected target's word on a read and
// holds it otherwise; open bus reads all ones.
// Assumes: target arrays return data in the request cycle.
module cart_rdata_reg
    import cart_mapper_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd_en,
    input  tgt_e          tgt,
    input  logic [DW-1:0] rom_data,
    input  logic [DW-1:0] sram_data,
    output logic [DW-1:0] rd_data
);
    // Register the read result, one cycle after the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data <= '1;
        end else if (rd_en) begin
            case (tgt)
                TGT_ROM:  rd_data <= rom_data;
                TGT_SRAM: rd_data <= sram_data;
                default:  rd_data <= '1;
            endcase
        end
    end

    // R9
    open_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && tgt == TGT_OPEN) |=> (rd_data == '1));

    // R11
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_data));

    // R6
    sram_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && tgt == TGT_SRAM) |=> (rd_data == $past(sram_data)));
endmodule

// File: rtl/cart_bank_mapper.sv
// Cartridge mapper top: decodes word accesses to ROM, SRAM or open bus,
// keeps the low-window view bit and gates SRAM writes.
// Assumes: cfg_* inputs static; bus_req is one cycle per access.
module cart_bank_mapper
    import cart_mapper_pkg::*;
#(
    parameter int BUS_AW      = 23,
    parameter int DW          = 16,
    parameter int ROM_AW      = 21,
    parameter int SRAM_AW     = 14,
    parameter int SRAM_WIN_AW = 15,
    parameter int LOW_WIN_AW  = 17,
    parameter int CTL_AW      = 7,
    parameter int VIEW_BIT    = 7,
    parameter logic [BUS_AW-1:0] SRAM_BASE_W = 23'h200000,
    parameter logic [BUS_AW-1:0] CTL_BASE_W  = 23'h000700,
    parameter logic [ROM_AW-1:0] SWAP_BASE_W = 21'h1C0000
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_sram_en,
    input  logic               cfg_sram_ro,
    input  logic               bus_req,
    input  logic               bus_we,
    input  logic [BUS_AW-1:0]  bus_waddr,
    input  logic [DW-1:0]      bus_wdata,
    output logic [DW-1:0]      bus_rdata,
    output logic [ROM_AW-1:0]  rom_addr,
    input  logic [DW-1:0]      rom_rdata,
    output logic [SRAM_AW-1:0] sram_addr,
    output logic               sram_we,
    output logic [DW-1:0]      sram_wdata,
    input  logic [DW-1:0]      sram_rdata
);
    localparam int LOW_TAG_W = BUS_AW - LOW_WIN_AW;

    tgt_e tgt;
    logic ctl_hit;
    logic view_hi;
    logic wr_en;
    logic rd_en;

    // Split the request into read and write strobes.
    always_comb begin
        wr_en = bus_req && bus_we;
        rd_en = bus_req && !bus_we;
    end

    cart_decode #(
        .BUS_AW(BUS_AW), .ROM_AW(ROM_AW), .SRAM_AW(SRAM_AW),
        .SRAM_WIN_AW(SRAM_WIN_AW), .LOW_WIN_AW(LOW_WIN_AW), .CTL_AW(CTL_AW),
        .SRAM_BASE_W(SRAM_BASE_W), .CTL_BASE_W(CTL_BASE_W),
        .SWAP_BASE_W(SWAP_BASE_W)
    ) i_decode (
        .waddr     (bus_waddr),
        .view_hi   (view_hi),
        .sram_en   (cfg_sram_en),
        .tgt       (tgt),
        .rom_addr  (rom_addr),
        .sram_addr (sram_addr),
        .ctl_hit   (ctl_hit)
    );

    cart_mode_reg i_mode (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .ctl_hit (ctl_hit),
        .wbit    (bus_wdata[VIEW_BIT]),
        .view_hi (view_hi)
    );

    cart_rdata_reg #(.DW(DW)) i_rdata (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_en     (rd_en),
        .tgt       (tgt),
        .rom_data  (rom_rdata),
        .sram_data (sram_rdata),
        .rd_data   (bus_rdata)
    );

    // SRAM write gating: window hit, not read-only; ROM never written.
    always_comb begin
        sram_we    = wr_en && (tgt == TGT_SRAM) && !cfg_sram_ro;
        sram_wdata = bus_wdata;
    end

    // R7
    sram_we_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sram_we |-> (bus_req && bus_we && cfg_sram_en && !cfg_sram_ro));

    // R4
    swap_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && view_hi && bus_waddr[BUS_AW-1:LOW_WIN_AW] == LOW_TAG_W'(0))
        |-> (rom_addr[ROM_AW-1:LOW_WIN_AW] == SWAP_BASE_W[ROM_AW-1:LOW_WIN_AW]));

    // R10
    ctl_no_sram_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && ctl_hit) |-> !sram_we);
endmodule

// File: tb/test_cart_bank_mapper.sv
`timescale 1ns/1ps
module test_cart_bank_mapper;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_sram_en = 1'b1;
    logic        cfg_sram_ro = 1'b0;
    logic        bus_req = 1'b0;
    logic        bus_we = 1'b0;
    logic [22:0] bus_waddr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic [20:0] rom_addr;
    logic [15:0] rom_rdata;
    logic [13:0] sram_addr;
    logic        sram_we;
    logic [15:0] sram_wdata;
    logic [15:0] sram_rdata;

    int total = 0;
    int bad = 0;

    always #2.5 clk = ~clk;

    cart_bank_mapper i_cart_bank_mapper (
        .clk(clk), .rst_n(rst_n), .cfg_sram_en(cfg_sram_en), .cfg_sram_ro(cfg_sram_ro),
        .bus_req(bus_req), .bus_we(bus_we), .bus_waddr(bus_waddr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .rom_addr(rom_addr), .rom_rdata(rom_rdata),
        .sram_addr(sram_addr), .sram_we(sram_we), .sram_wdata(sram_wdata),
        .sram_rdata(sram_rdata)
    );

    // ROM model: content is a function of the word address.
    function automatic logic [15:0] rom_word(input logic [20:0] a);
        return a[15:0] ^ {a[20:16], 11'h000};
    endfunction
    assign rom_rdata = rom_word(rom_addr);

    // SRAM model (1K words; the sram_addr port is checked separately).
    logic [15:0] smem [1024];
    assign sram_rdata = smem[sram_addr[9:0]];
    always @(posedge clk) if (sram_we) smem[sram_addr[9:0]] <= sram_wdata;

    logic [20:0] cap_rom;
    logic [13:0] cap_sram;
    logic        cap_we;

    task automatic chk(input string rq, input logic [23:0] act, input logic [23:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", rq, act, exp);
        end
    endtask

    // One access: request for one cycle, result valid at the next negedge.
    task automatic access(input logic we, input logic [23:0] baddr, input logic [15:0] d);
        @(negedge clk);
        bus_req = 1'b1; bus_we = we; bus_waddr = baddr[23:1]; bus_wdata = d;
        #1;
        cap_rom = rom_addr; cap_sram = sram_addr; cap_we = sram_we;
        @(negedge clk);
        bus_req = 1'b0; bus_we = 1'b0;
    endtask

    typedef struct packed {
        logic        we;
        logic [23:0] baddr;
        logic [15:0] wdata;
        logic        lit;   // 1: exp is a literal word; 0: exp is a ROM byte address
        logic [23:0] exp;
    } vec_t;

    localparam int NV = 24;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 24'h000100, 16'h0000, 1'b0, 24'h000100}, // R1 R3 view 0 after reset
        '{1'b0, 24'h03FFFE, 16'h0000, 1'b0, 24'h03FFFE}, // R3 top of low window
        '{1'b1, 24'h000E00, 16'h0080, 1'b0, 24'h000000}, // R2 set view
        '{1'b0, 24'h000100, 16'h0000, 1'b0, 24'h380100}, // R4
        '{1'b0, 24'h03FFFE, 16'h0000, 1'b0, 24'h3BFFFE}, // R4
        '{1'b0, 24'h040000, 16'h0000, 1'b0, 24'h040000}, // R5 view 1
        '{1'b0, 24'h3FFFFE, 16'h0000, 1'b0, 24'h3FFFFE}, // R5 view 1
        '{1'b1, 24'h000EFE, 16'h007F, 1'b0, 24'h000000}, // R2 clear view, window end
        '{1'b0, 24'h000100, 16'h0000, 1'b0, 24'h000100}, // R3
        '{1'b1, 24'h000F00, 16'h0080, 1'b0, 24'h000000}, // R10 just past window
        '{1'b0, 24'h000100, 16'h0000, 1'b0, 24'h000100}, // R10 view unchanged
        '{1'b1, 24'h000DFE, 16'h00FF, 1'b0, 24'h000000}, // R10 just below window
        '{1'b0, 24'h000000, 16'h0000, 1'b0, 24'h000000}, // R10 view unchanged
        '{1'b0, 24'h3FFFFE, 16'h0000, 1'b0, 24'h3FFFFE}, // R5 view 0
        '{1'b1, 24'h400000, 16'h1234, 1'b0, 24'h000000}, // R7
        '{1'b0, 24'h400000, 16'h0000, 1'b1, 24'h001234}, // R6
        '{1'b0, 24'h408000, 16'h0000, 1'b1, 24'h001234}, // R6 mirror
        '{1'b1, 24'h40FFFE, 16'hBEEF, 1'b0, 24'h000000}, // R7 window end
        '{1'b0, 24'h407FFE, 16'h0000, 1'b1, 24'h00BEEF}, // R6 mirror
        '{1'b1, 24'h000E10, 16'h0080, 1'b0, 24'h000000}, // R2 view 1
        '{1'b1, 24'h400010, 16'h55AA, 1'b0, 24'h000000}, // R7 write with view 1
        '{1'b0, 24'h400010, 16'h0000, 1'b1, 24'h0055AA}, // R7
        '{1'b0, 24'h410000, 16'h0000, 1'b1, 24'h00FFFF}, // R9 above SRAM window
        '{1'b0, 24'hFFFFFE, 16'h0000, 1'b1, 24'h00FFFF}  // R9 top of space
    };

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 rdata after reset", {8'h0, bus_rdata}, 24'h00FFFF);

        for (int i = 0; i < NV; i++) begin
            access(VECS[i].we, VECS[i].baddr, VECS[i].wdata);
            if (VECS[i].we) begin
                chk($sformatf("vec%0d R7/R10 sram_we", i), {23'h0, cap_we},
                    {23'h0, (VECS[i].baddr >= 24'h400000 && VECS[i].baddr <= 24'h40FFFF)});
            end else if (VECS[i].lit) begin
                chk($sformatf("vec%0d read", i), {8'h0, bus_rdata}, VECS[i].exp);
            end else begin
                chk($sformatf("vec%0d rom read", i), {8'h0, bus_rdata},
                    {8'h0, rom_word(VECS[i].exp[21:1])});
            end
        end

        // R6: SRAM word address is the low 14 bits of the bus word address
        access(1'b0, 24'h40FFFE, 16'h0);
        chk("R6 sram_addr", {10'h0, cap_sram}, 24'h003FFF);

        // R8: read-only blocks writes
        cfg_sram_ro = 1'b1;
        access(1'b1, 24'h400000, 16'h9999);
        chk("R8 ro sram_we", {23'h0, cap_we}, 24'h0);
        access(1'b0, 24'h400000, 16'h0);
        chk("R8 ro contents", {8'h0, bus_rdata}, 24'h001234);
        cfg_sram_ro = 1'b0;

        // R8: disabled SRAM reads open bus and is not written
        cfg_sram_en = 1'b0;
        access(1'b0, 24'h400000, 16'h0);
        chk("R8 disabled read", {8'h0, bus_rdata}, 24'h00FFFF);
        access(1'b1, 24'h400000, 16'h7777);
        chk("R8 disabled sram_we", {23'h0, cap_we}, 24'h0);
        cfg_sram_en = 1'b1;
        access(1'b0, 24'h400000, 16'h0);
        chk("R8 contents kept", {8'h0, bus_rdata}, 24'h001234);

        // R11: read data holds through idle and write cycles (view is 1)
        access(1'b0, 24'h000100, 16'h0);
        chk("R11 read", {8'h0, bus_rdata}, {8'h0, rom_word(21'h1C0080)});
        bus_waddr = 23'h000400;
        repeat (3) @(negedge clk);
        chk("R11 idle hold", {8'h0, bus_rdata}, {8'h0, rom_word(21'h1C0080)});
        access(1'b1, 24'h040000, 16'hAAAA);
        chk("R11 hold over write", {8'h0, bus_rdata}, {8'h0, rom_word(21'h1C0080)});
        chk("R10 rom write no sram_we", {23'h0, cap_we}, 24'h0);
        access(1'b0, 24'h040000, 16'h0);
        chk("R10 rom unchanged", {8'h0, bus_rdata}, {8'h0, rom_word(21'h020000)});

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog act=running exp=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule